// File: doc/BRIEF.md
# Interrupt Request Capture Latch

This block turns eight raw interrupt request levels into a registered pending-request vector. Each line is either edge-captured or level-following, as chosen by one bit of a trigger-mode register. An edge-captured request is held until it is acknowledged. A level-following request mirrors its input on every clock. The block also keeps the previous sampled level of every line, so that edges can be detected.

When the downstream controller acknowledges a line, the block applies the side effects of that acknowledge:
- it sets the line's in-service bit, or, in automatic end-of-interrupt mode, optionally moves the priority rotation offset to the line after the acknowledged one;
- it drops the pending bit of an edge-mode line.

Priority resolution sits outside this block and consumes the pending vector, the in-service vector and the rotation offset.

An initialization clear input returns the capture state to idle without touching the trigger-mode register. The synchronous active-low reset clears everything.

Top module: `irq_req_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) has its pending bit equal to its input level as sampled at the previous clock edge, high or low.
- R2: A line whose trigger-mode bit is 0 (edge mode) sets its pending bit only on a clock where the input is sampled high and the previous sampled level was low. A steady high input does not set it again.
- R3: In edge mode a low input leaves an already set pending bit set.
- R4: An acknowledge (ack_valid high, ack_line = n) with auto_eoi low sets in-service bit n on the next edge.
- R5: An acknowledge with auto_eoi and rot_on_aeoi both high sets the rotation offset to n+1, wrapping from 7 to 0. It pulses rot_upd_o high for one cycle and leaves the in-service vector unchanged.
- R6: An acknowledge with auto_eoi high and rot_on_aeoi low changes neither the in-service vector nor the rotation offset, and rot_upd_o stays low.
- R7: An acknowledge clears the pending bit of line n when line n is in edge mode. A level-mode line's pending bit still follows its input.
- R8: When an edge-mode line sees a new rising edge in the same cycle that it is acknowledged, its pending bit stays set, so the new request is kept.
- R9: The trigger-mode register resets to all zeros (every line in edge mode). A write stores wr_data AND TRIG_WMASK, and the register holds its value when no write is made.
- R10: init_clr clears the pending, in-service and previous-level vectors, the rotation offset and rot_upd_o. It leaves the trigger-mode register unchanged.
- R11: After rst_n low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_clr | input | 1 | Initialization clear of the capture state |
| req_lvl | input | 8 | Synchronous request levels, one per line |
| trig_we | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 8 | Trigger-mode write data (1 = level, 0 = edge) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Acknowledged line number |
| auto_eoi | input | 1 | Automatic end-of-interrupt enable |
| rot_on_aeoi | input | 1 | Rotate on automatic end-of-interrupt |
| pend_o | output | 8 | Pending-request vector |
| insvc_o | output | 8 | In-service vector |
| rot_off_o | output | 3 | Priority rotation offset |
| rot_upd_o | output | 1 | One-cycle pulse when the offset was rewritten |
| trig_mode_o | output | 8 | Current trigger-mode register |

## Verification
The bench targets four corner cases:
- A line that stays high across several cycles. A design that compares against the current pending bit, rather than the previous level, would re-arm it after an acknowledge.
- A new edge that lands in the same cycle as its own acknowledge. A design that lets the clear win would lose that request.
- A level line that is acknowledged. A design that clears it anyway shows a one-cycle dropout.
- A line 7 rotation, which a design without the wrap would turn into offset 0 only by accident of width.

The trigger-mode write uses a mask with cleared bits, to catch a design that stores the unmasked data. An initialization clear is applied while the lines are in level mode, to catch a design that wipes the trigger register.

// File: rtl/irq_latch_pkg.sv
// Package: shared types for the interrupt request capture latch.
// Assumes one trigger-mode bit per line: 0 selects edge, 1 selects level.
package irq_latch_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/irq_line_cell.sv
// Module: capture logic for a single interrupt line.
// Keeps the pending bit and the previously sampled level. In level mode the
// pending bit follows the input. In edge mode it is set on a low-to-high
// transition and cleared by an acknowledge of this line; a new edge wins over
// a simultaneous acknowledge. Assumes req_lvl is already synchronous to clk.
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_clr,
    input  logic       req_lvl,
    input  trig_mode_e mode,
    input  logic       ack_hit,
    output logic       pend,
    output logic       last_lvl
);

    logic rise;

    // Purpose: detect a rising edge against the registered previous level.
    always_comb begin
        rise = req_lvl & ~last_lvl;
    end

    // Purpose: update the previous level and the pending bit once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            pend     <= 1'b0;
            last_lvl <= 1'b0;
        end else begin
            last_lvl <= req_lvl;
            if (mode == TRIG_LEVEL) begin
                pend <= req_lvl;
            end else begin
                pend <= rise | (pend & ~ack_hit);
            end
        end
    end

    // R1: a level-mode line mirrors the previous sample.
    assert_level_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!init_clr) && $past(mode == TRIG_LEVEL))
        |-> (pend == $past(req_lvl)));

    // R2: an edge-mode pending bit rises only after a low-to-high sample.
    assert_edge_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == TRIG_EDGE) && $rose(pend))
        |-> $past(req_lvl && !last_lvl));

    // R7: an acknowledged edge line without a new edge is cleared.
    assert_ack_clears_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack_hit) && $past(mode == TRIG_EDGE)
         && $past(!(req_lvl && !last_lvl)))
        |-> !pend);

endmodule

// File: rtl/irq_trig_reg.sv
// Module: trigger-mode register.
// Holds one mode bit per line. Only rst_n clears it; the initialization clear
// does not. Writes are ANDed with the per-instance writable mask.
module irq_trig_reg #(
    parameter int unsigned           NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0]  TRIG_WMASK = {NUM_LINES{1'b1}}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_we,
    input  logic [NUM_LINES-1:0] trig_wdata,
    output logic [NUM_LINES-1:0] trig_q
);

    // Purpose: store masked mode bits on a write; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else if (trig_we) begin
            trig_q <= trig_wdata & TRIG_WMASK;
        end
    end

    // R9: without a write the register keeps its value.
    assert_trig_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!trig_we)) |-> $stable(trig_q));

endmodule

// File: rtl/irq_ack_ctrl.sv
// Module: acknowledge side effects on the in-service vector and the offset.
// Without auto-EOI an acknowledge sets the line's in-service bit. With
// auto-EOI and rotation enabled it moves the offset to the next line and
// pulses rot_upd. Line numbers at or above NUM_LINES are ignored.
module irq_ack_ctrl #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned LW        = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_clr,
    input  logic                 ack_valid,
    input  logic [LW-1:0]        ack_line,
    input  logic                 auto_eoi,
    input  logic                 rot_on_aeoi,
    output logic [NUM_LINES-1:0] insvc_q,
    output logic [LW-1:0]        rot_off_q,
    output logic                 rot_upd_q
);

    logic          ack_ok;
    logic          set_isr;
    logic          do_rot;
    logic [LW-1:0] next_off;

    // Purpose: qualify the acknowledge and work out the next rotation offset.
    always_comb begin
        ack_ok   = ack_valid && ({1'b0, ack_line} < (LW+1)'(NUM_LINES));
        set_isr  = ack_ok && !auto_eoi;
        do_rot   = ack_ok && auto_eoi && rot_on_aeoi;
        next_off = (ack_line == LW'(NUM_LINES - 1)) ? '0 : ack_line + 1'b1;
    end

    // Purpose: apply the acknowledge to the in-service vector and the offset.
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            insvc_q   <= '0;
            rot_off_q <= '0;
            rot_upd_q <= 1'b0;
        end else begin
            rot_upd_q <= do_rot;
            if (set_isr) begin
                insvc_q <= insvc_q | (NUM_LINES'(1) << ack_line);
            end
            if (do_rot) begin
                rot_off_q <= next_off;
            end
        end
    end

    // R4: an acknowledge without auto-EOI leaves the line in service.
    assert_isr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack_valid && !auto_eoi && !init_clr))
        |-> insvc_q[$past(ack_line)]);

    // R5: a rotating auto-EOI pulses the update and keeps in-service as it was.
    assert_rot_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack_valid && auto_eoi && rot_on_aeoi && !init_clr))
        |-> (rot_upd_q && $stable(insvc_q)));

    // R6: a plain auto-EOI touches neither the offset nor the in-service vector.
    assert_aeoi_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack_valid && auto_eoi && !rot_on_aeoi && !init_clr))
        |-> (!rot_upd_q && $stable(insvc_q) && $stable(rot_off_q)));

endmodule

// File: rtl/irq_req_latch.sv
// Module: top of the interrupt request capture latch.
// Instantiates one capture cell per line, the trigger-mode register and the
// acknowledge controller. All outputs are registered, so every input change
// shows up one clock after it is sampled.
module irq_req_latch
    import irq_latch_pkg::*;
#(
    parameter int unsigned          NUM_LINES  = 8,
    parameter logic [NUM_LINES-1:0] TRIG_WMASK = {NUM_LINES{1'b1}},
    localparam int unsigned         LW         = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_clr,
    input  logic [NUM_LINES-1:0] req_lvl,
    input  logic                 trig_we,
    input  logic [NUM_LINES-1:0] trig_wdata,
    input  logic                 ack_valid,
    input  logic [LW-1:0]        ack_line,
    input  logic                 auto_eoi,
    input  logic                 rot_on_aeoi,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] insvc_o,
    output logic [LW-1:0]        rot_off_o,
    output logic                 rot_upd_o,
    output logic [NUM_LINES-1:0] trig_mode_o
);

    logic [NUM_LINES-1:0] trig_q;
    logic [NUM_LINES-1:0] last_q;
    logic [NUM_LINES-1:0] hit;

    irq_trig_reg #(
        .NUM_LINES  (NUM_LINES),
        .TRIG_WMASK (TRIG_WMASK)
    ) trig_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_we    (trig_we),
        .trig_wdata (trig_wdata),
        .trig_q     (trig_q)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        // Purpose: decode the acknowledge for this line.
        always_comb begin
            hit[i] = ack_valid && (ack_line == LW'(i));
        end

        irq_line_cell cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .init_clr (init_clr),
            .req_lvl  (req_lvl[i]),
            .mode     (trig_mode_e'(trig_q[i])),
            .ack_hit  (hit[i]),
            .pend     (pend_o[i]),
            .last_lvl (last_q[i])
        );
    end

    irq_ack_ctrl #(
        .NUM_LINES (NUM_LINES),
        .LW        (LW)
    ) ack_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_clr    (init_clr),
        .ack_valid   (ack_valid),
        .ack_line    (ack_line),
        .auto_eoi    (auto_eoi),
        .rot_on_aeoi (rot_on_aeoi),
        .insvc_q     (insvc_o),
        .rot_off_q   (rot_off_o),
        .rot_upd_q   (rot_upd_o)
    );

    // Purpose: expose the trigger-mode register.
    always_comb begin
        trig_mode_o = trig_q;
    end

    // R10: an initialization clear leaves the trigger modes alone.
    assert_init_keeps_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(init_clr && !trig_we)) |-> $stable(trig_mode_o));

    // R10: an initialization clear empties the capture state.
    assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(init_clr))
        |-> (pend_o == '0 && insvc_o == '0 && last_q == '0 && rot_off_o == '0));

endmodule

// File: tb/irq_req_latch_tb_top.sv
// Bench: drives the latch and compares it on every clock against a
// behavioural model kept in plain variables.
module irq_req_latch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] WMASK = 8'hF3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_clr = 1'b0;
    logic [7:0] req_lvl = '0;
    logic       trig_we = 1'b0;
    logic [7:0] trig_wdata = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_line = '0;
    logic       auto_eoi = 1'b0;
    logic       rot_on_aeoi = 1'b0;
    logic [7:0] pend_o, insvc_o, trig_mode_o;
    logic [2:0] rot_off_o;
    logic       rot_upd_o;

    int n_checks = 0;
    int n_fail = 0;

    // model state
    bit [7:0] m_pend = '0, m_isr = '0, m_last = '0, m_trig = '0;
    int       m_off = 0;
    bit       m_upd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_req_latch #(.NUM_LINES(8), .TRIG_WMASK(WMASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .req_lvl(req_lvl),
        .trig_we(trig_we), .trig_wdata(trig_wdata), .ack_valid(ack_valid),
        .ack_line(ack_line), .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
        .pend_o(pend_o), .insvc_o(insvc_o), .rot_off_o(rot_off_o),
        .rot_upd_o(rot_upd_o), .trig_mode_o(trig_mode_o));

    task automatic model_step();
        bit [7:0] np = m_pend;
        bit [7:0] nt = m_trig;
        if (!rst_n) begin
            m_pend = '0; m_isr = '0; m_last = '0; m_trig = '0; m_off = 0; m_upd = 0;
            return;
        end
        if (trig_we) nt = trig_wdata & WMASK;
        if (init_clr) begin
            m_pend = '0; m_isr = '0; m_last = '0; m_off = 0; m_upd = 0;
            m_trig = nt;
            return;
        end
        for (int i = 0; i < 8; i++) begin
            if (m_trig[i]) np[i] = req_lvl[i];
            else if (req_lvl[i] && !m_last[i]) np[i] = 1'b1;
            else if (ack_valid && ack_line == i) np[i] = 1'b0;
        end
        m_upd = 1'b0;
        if (ack_valid) begin
            if (!auto_eoi) m_isr[ack_line] = 1'b1;
            else if (rot_on_aeoi) begin
                m_off = (int'(ack_line) + 1) % 8;
                m_upd = 1'b1;
            end
        end
        m_pend = np; m_last = req_lvl; m_trig = nt;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: model on the edge, compare at the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, "pend", int'(pend_o), int'(m_pend));
        chk(tag, "insvc", int'(insvc_o), int'(m_isr));
        chk(tag, "rot_off", int'(rot_off_o), m_off);
        chk(tag, "rot_upd", int'(rot_upd_o), int'(m_upd));
        chk(tag, "trig", int'(trig_mode_o), int'(m_trig));
    endtask

    task automatic ack(int line, bit aeoi, bit rot);
        ack_valid = 1'b1; ack_line = 3'(line); auto_eoi = aeoi; rot_on_aeoi = rot;
    endtask

    task automatic no_ack();
        ack_valid = 1'b0; auto_eoi = 1'b0; rot_on_aeoi = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        req_lvl = 8'h01;                    // high during reset must not linger
        tick("R11"); tick("R11");
        rst_n = 1'b1; req_lvl = 8'h00;
        tick("R11");
        // edge capture on line 0
        req_lvl = 8'h01; tick("R2");
        tick("R2");                         // steady high, no re-arm
        req_lvl = 8'h00; tick("R3");        // low keeps pending
        tick("R3");
        // acknowledge line 0 without auto-EOI
        ack(0, 0, 0); tick("R4"); no_ack(); tick("R7");
        // steady high after ack must not re-arm
        req_lvl = 8'h02; tick("R2"); ack(1, 0, 0); tick("R7"); no_ack(); tick("R2");
        req_lvl = 8'h00;
        // trigger register write, masked
        trig_we = 1'b1; trig_wdata = 8'hFF; tick("R9"); trig_we = 1'b0; tick("R9");
        // level following
        req_lvl = 8'h11; tick("R1"); req_lvl = 8'h10; tick("R1");
        ack(4, 0, 0); tick("R7"); no_ack(); tick("R1");
        req_lvl = 8'h00; tick("R1");
        // same-cycle edge and acknowledge on edge line 3
        req_lvl = 8'h08; tick("R2"); req_lvl = 8'h00; tick("R3");
        req_lvl = 8'h08; ack(3, 0, 0); tick("R8"); no_ack(); tick("R8");
        req_lvl = 8'h00;
        // auto-EOI with rotation, including the wrap
        ack(7, 1, 1); tick("R5"); no_ack(); tick("R5");
        ack(2, 1, 1); tick("R5"); no_ack(); tick("R5");
        ack(5, 1, 0); tick("R6"); no_ack(); tick("R6");
        // initialization clear keeps the trigger modes
        req_lvl = 8'h40; tick("R1");
        init_clr = 1'b1; tick("R10"); init_clr = 1'b0; tick("R10");
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            req_lvl   = 8'($urandom);
            ack_valid = ($urandom % 3) == 0;
            ack_line  = 3'($urandom);
            auto_eoi  = ($urandom % 2) == 0;
            rot_on_aeoi = ($urandom % 2) == 0;
            trig_we   = ($urandom % 29) == 0;
            trig_wdata = 8'($urandom);
            init_clr  = ($urandom % 53) == 0;
            tick("R7");
        end
        no_ack(); trig_we = 1'b0; init_clr = 1'b0;
        tick("R7");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule